// File: doc/BRIEF.md
# Programmable Trigger Delay Generator

This block is a clocked stand-in for a programmable one-shot delay. A rising edge on the trigger input starts a delay cycle. The output goes high after a fixed minimum latency plus a delay proportional to an 8-bit code. The code reaches the timing logic through a register that follows the data pins while its hold input is low and freezes them while hold is high.

A level-sensitive clear input forces the output low and abandons any running cycle. With the loop-back mode input set, the block clears itself from its own output and produces a one-cycle pulse. With the mode input low, the output stays high until the clear input is raised. A trigger that arrives too soon after a code latch or after a clear still starts a cycle, but the block raises a one-cycle warning for it.

All timing values are elaboration parameters counted in clock cycles: the full-scale delay, the minimum latency (at least 1), the settle window and the recovery window.

Top module: `trig_delay_gen`

## Requirements
- R1: The active code equals `code_in` while `hold` is low, and keeps its last value while `hold` is high. Bit 0 of the code is the least significant bit.
- R2: Only a low-to-high change of `trig`, seen on a clock edge, starts a delay cycle. Holding `trig` high starts nothing further.
- R3: If a cycle is accepted at clock edge n, `pulse_out` goes high at edge n + MIN_LAT + floor(code × FULL_SCALE / 256). The code used is the active code at edge n, so 00h adds no delay and FFh adds the most.
- R4: While `clr` is high, `pulse_out` is low from the next edge on, any running cycle is dropped, and trigger edges are ignored. A trigger that is still high when `clr` falls starts no cycle.
- R5: With `self_clr` high, each output pulse lasts exactly one clock cycle.
- R6: With `self_clr` low, `pulse_out` stays high until `clr` is raised.
- R7: A cycle accepted at the same edge as a rising `hold`, or within SETTLE_CYC edges after it, raises `early_flag`.
- R8: A cycle accepted within RECOV_CYC edges after the last edge at which a clear was seen raises `early_flag`. A clear here means `clr`, or the output while `self_clr` is high.
- R9: `early_flag` is high for one cycle, the cycle right after the accepting edge, and the flagged cycle still runs to completion.
- R10: A trigger edge that arrives while a delay cycle is running, including at the edge where that cycle completes, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | CODE_W | Delay code pins |
| hold | input | 1 | High freezes the code register; low makes it follow `code_in` |
| trig | input | 1 | Trigger; a rising edge starts a delay cycle |
| clr | input | 1 | Level-sensitive clear of the output and the timing state |
| self_clr | input | 1 | High makes the output clear itself (loop-back mode) |
| pulse_out | output | 1 | Delayed output |
| early_flag | output | 1 | One-cycle warning for a trigger inside the settle or recovery window |

## Verification
Two events can fall on the same clock edge: a trigger edge and the rising edge of `hold`. This is driven on purpose, and the bench expects both the start of a cycle and a raised warning from that one edge. The other collisions are also provoked: a trigger at the last edge and at the first edge past each window, a trigger rising while `clr` is high, and a trigger held high across the falling edge of `clr`. A behavioural model keeps an absolute due time for each cycle and the edge numbers of the last clear and the last latch rise. Its predictions of `pulse_out` and `early_flag` are compared with the design on every cycle.

// File: rtl/trig_delay_gen.sv
module trig_delay_gen #(
  parameter int CODE_W     = 8,
  parameter int FULL_SCALE = 64,
  parameter int MIN_LAT    = 3,
  parameter int SETTLE_CYC = 4,
  parameter int RECOV_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              hold,
  input  logic              trig,
  input  logic              clr,
  input  logic              self_clr,
  output logic              pulse_out,
  output logic              early_flag
);
  localparam int PW = CODE_W + $clog2(FULL_SCALE + 1);
  localparam int CW = $clog2(MIN_LAT + FULL_SCALE + 1);
  localparam int SW = $clog2(SETTLE_CYC + 2);
  localparam int RW = $clog2(RECOV_CYC + 2);

  logic [CODE_W-1:0] code_q, act_code;
  logic [PW-1:0]     prod;
  logic [CW-1:0]     total, cnt;
  logic [SW-1:0]     set_cnt;
  logic [RW-1:0]     rec_cnt;
  logic trig_q, hold_q, busy;
  logic clr_eff, trig_rise, hold_rise, accept, in_window;

  assign act_code  = hold ? code_q : code_in;
  assign prod      = PW'(act_code) * PW'(FULL_SCALE);
  assign total     = CW'(MIN_LAT) + CW'(prod >> CODE_W);
  assign clr_eff   = clr | (self_clr & pulse_out);
  assign trig_rise = trig & ~trig_q;
  assign hold_rise = hold & ~hold_q;
  assign accept    = trig_rise & ~busy & ~clr_eff;
  assign in_window = hold_rise | (set_cnt != '0) | (rec_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q     <= '0;
      trig_q     <= 1'b0;
      hold_q     <= 1'b0;
      early_flag <= 1'b0;
      set_cnt    <= '0;
      rec_cnt    <= '0;
      busy       <= 1'b0;
      cnt        <= '0;
      pulse_out  <= 1'b0;
    end else begin
      code_q     <= act_code;
      trig_q     <= trig;
      hold_q     <= hold;
      early_flag <= accept & in_window;
      if (hold_rise)          set_cnt <= SW'(SETTLE_CYC);
      else if (set_cnt != '0) set_cnt <= set_cnt - 1'b1;
      if (clr_eff) begin
        rec_cnt   <= RW'(RECOV_CYC);
        busy      <= 1'b0;
        cnt       <= '0;
        pulse_out <= 1'b0;
      end else begin
        if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
        if (busy) begin
          if (cnt == '0) begin
            pulse_out <= 1'b1;
            busy      <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else if (accept) begin
          busy <= 1'b1;
          cnt  <= total - 1'b1;
        end
      end
    end
  end

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> (act_code == $past(act_code)));
  assert_fire_from_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(busy));
  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse_out);
  assert_narrow_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (self_clr && pulse_out) |=> !pulse_out);
  assert_level_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && !clr && !self_clr) |=> pulse_out);
  assert_flag_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    early_flag |=> !early_flag);
endmodule

// File: tb/trig_delay_gen_tb.sv
`timescale 1ns/1ps
module trig_delay_gen_tb;
  localparam int FS = 64, ML = 3, ST = 4, RC = 3;

  logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, trig = 1'b0, clr = 1'b0, self_clr = 1'b1;
  logic [7:0] code_in = 8'h00;
  logic pulse_out, early_flag;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string req = "R4";

  int e_out = 0, e_flag = 0, due = -1, last_clr = -1000, last_rise = -1000, edge_n = 0;
  logic [7:0] m_code = 8'h00;
  bit m_tp = 1'b0, m_hp = 1'b0;

  trig_delay_gen #(.CODE_W(8), .FULL_SCALE(FS), .MIN_LAT(ML), .SETTLE_CYC(ST), .RECOV_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .hold(hold), .trig(trig), .clr(clr),
    .self_clr(self_clr), .pulse_out(pulse_out), .early_flag(early_flag));

  always #2 clk = ~clk;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    logic [7:0] act;
    bit clre, rise;
    edge_n++;
    if (!rst_n) begin
      e_out = 0; e_flag = 0; due = -1; last_clr = -1000; last_rise = -1000;
      m_code = 8'h00; m_tp = 1'b0; m_hp = 1'b0;
    end else begin
      act  = hold ? m_code : code_in;
      clre = clr || (self_clr && e_out == 1);
      rise = trig && !m_tp;
      if (hold && !m_hp) last_rise = edge_n;
      e_flag = 0;
      if (clre) begin
        due = -1; e_out = 0; last_clr = edge_n;
      end else if (due != -1) begin
        if (due == edge_n) begin e_out = 1; due = -1; end
      end else if (rise) begin
        due = edge_n + ML + (int'(act) * FS) / 256;
        e_flag = ((edge_n - last_clr) <= RC || (edge_n - last_rise) <= ST) ? 1 : 0;
      end
      m_code = act; m_tp = trig; m_hp = hold;
    end
  end

  always @(negedge clk) begin
    cyc++;
    n_cmp += 2;
    if (pulse_out !== 1'(e_out)) begin
      n_bad++;
      $display("FAIL %s pulse_out got %b expected %0d at cycle %0d", req, pulse_out, e_out, cyc);
    end
    if (early_flag !== 1'(e_flag)) begin
      n_bad++;
      $display("FAIL %s early_flag got %b expected %0d at cycle %0d", req, early_flag, e_flag, cyc);
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired got running expected finished");
      finish_run();
    end
  end

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(1); trig = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(10);
    req = "R3";
    foreach (code_in[i]) begin end
    code_in = 8'h00; tick(2); pulse_trig(); tick(80);
    code_in = 8'h01; tick(2); pulse_trig(); tick(80);
    code_in = 8'h04; tick(2); pulse_trig(); tick(80);
    code_in = 8'h80; tick(2); pulse_trig(); tick(80);
    code_in = 8'hFF; tick(2); pulse_trig(); tick(80);
    req = "R5";
    code_in = 8'h08; tick(2); pulse_trig(); tick(20);
    req = "R1";
    code_in = 8'd10; hold = 1'b1; tick(10);
    code_in = 8'd200; pulse_trig(); tick(80);
    hold = 1'b0; tick(2); pulse_trig(); tick(80);
    req = "R2";
    code_in = 8'd5; trig = 1'b1; tick(100); trig = 1'b0; tick(10);
    req = "R10";
    code_in = 8'd100; pulse_trig(); tick(5); pulse_trig(); tick(80);
    code_in = 8'd0; pulse_trig(); tick(1); pulse_trig(); tick(20);
    req = "R4";
    code_in = 8'hFF; pulse_trig(); tick(20);
    clr = 1'b1; tick(2); trig = 1'b1; tick(2); clr = 1'b0; tick(3); trig = 1'b0; tick(80);
    req = "R6";
    self_clr = 1'b0; code_in = 8'd20; pulse_trig(); tick(40);
    clr = 1'b1; tick(1); clr = 1'b0; tick(10);
    req = "R7";
    self_clr = 1'b1; code_in = 8'd30; tick(2);
    hold = 1'b1; tick(2); pulse_trig(); tick(80);
    hold = 1'b0; tick(1); hold = 1'b1; pulse_trig(); tick(80);
    hold = 1'b0; tick(1); hold = 1'b1; tick(ST); pulse_trig(); tick(80);
    hold = 1'b0; tick(1); hold = 1'b1; tick(ST + 1); pulse_trig(); tick(80);
    hold = 1'b0; tick(10);
    req = "R8";
    clr = 1'b1; tick(2); clr = 1'b0; pulse_trig(); tick(80);
    clr = 1'b1; tick(1); clr = 1'b0; tick(RC - 1); pulse_trig(); tick(80);
    clr = 1'b1; tick(1); clr = 1'b0; tick(RC); pulse_trig(); tick(80);
    req = "R9";
    code_in = 8'd40; pulse_trig(); tick(40);
    finish_run();
  end
endmodule